// File: doc/BRIEF.md
# Carry-save tree multiplier, 8 by 8 unsigned

This block multiplies two 8-bit unsigned operands and returns the full 16-bit product. A registered operand pair is expanded into eight partial products, one per multiplier bit. A fixed arrangement of six 3:2 carry-save adders reduces them to a redundant sum/carry pair. A two-level carry-lookahead adder then turns that pair into the binary result, which is captured in an output register.

Between the operand register and the result register the whole datapath is combinational. One operand pair can therefore be accepted on every clock, and each result emerges a fixed number of cycles later, flagged by its own valid bit. The reduction order is fixed. Some later adders take the sums of earlier adders again, and every carry vector moves up one bit position before it is used. The partial-product width and the adder schedule are built for 8-bit operands.

Top module: `wtree_mul`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `product` is 0.
- R2: For every pair of unsigned 8-bit operands, the reported `product` equals `a` times `b` as a 16-bit unsigned value (0xFF times 0xFF gives 0xFE01).
- R3: An operand pair is captured at a rising clock edge where `in_valid` is 1. `out_valid` is 1 for exactly the cycle that follows that capture edge, and 0 after any edge that captured nothing.
- R4: A new operand pair may be presented on every consecutive cycle. Each result appears in order, two edges after its operands were presented.
- R5: While `in_valid` is 0, the values on `a` and `b` are ignored and `product` keeps its last value.
- R6: Partial product i is the multiplicand `a` shifted left by i when bit i of `b` is 1, and zero otherwise. As a result, `b` equal to 1 shifted left by i yields `a` shifted left by i, and `b` equal to 0 yields 0.
- R7: The final redundant pair never carries weight at or above bit 16, so their sum fits in 16 bits for all inputs.
- R8: The lookahead adder uses 4-bit groups whose group generate and propagate terms feed a second lookahead level. Its 16-bit output equals the sum of the redundant pair modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `a`/`b` is to be captured |
| a | input | 8 | Multiplicand |
| b | input | 8 | Multiplier |
| out_valid | output | 1 | `product` holds a new result this cycle |
| product | output | 16 | Registered unsigned product |

## Verification
An operand pair presented before rising edge k is captured at k, and its product and `out_valid` are registered at edge k+1. The bench drives inputs on falling edges and reads the result on the falling edge two clocks after it drove the pair. In the exhaustive sweep it keeps this two-cycle distance while streaming one pair per cycle. Idle-input checks read `product` and `out_valid` one and two cycles after the change on `a`/`b`, which is when a wrongful capture would have become visible.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
  localparam int unsigned MUL_W   = 8;
  localparam int unsigned PROD_W  = 2 * MUL_W;
  localparam int unsigned LA_GRP  = 4;

  typedef logic [PROD_W-1:0] tree_t;

  // Bitwise sum output of a 3:2 compressor.
  function automatic tree_t xor3(input tree_t x, input tree_t y, input tree_t z);
    return x ^ y ^ z;
  endfunction

  // Bitwise majority, the unshifted carry of a 3:2 compressor.
  function automatic tree_t maj3(input tree_t x, input tree_t y, input tree_t z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/wtm_ppgen.sv
module wtm_ppgen
  import wtm_pkg::*;
#(
  parameter int unsigned OP_W = MUL_W
) (
  input  logic [OP_W-1:0] mcand,
  input  logic [OP_W-1:0] mplier,
  output tree_t           pp [OP_W]
);
  for (genvar i = 0; i < OP_W; i++) begin : g_row
    assign pp[i] = mplier[i] ? (tree_t'(mcand) << i) : '0;
  end
endmodule

// File: rtl/wtm_csa.sv
module wtm_csa
  import wtm_pkg::*;
(
  input  tree_t x,
  input  tree_t y,
  input  tree_t z,
  output tree_t sum,
  output tree_t carry_sh
);
  // Carry leaves already moved one place up, ready for the next stage.
  assign sum      = xor3(x, y, z);
  assign carry_sh = maj3(x, y, z) << 1;
endmodule

// File: rtl/wtm_cla.sv
module wtm_cla #(
  parameter int unsigned W = 16,
  parameter int unsigned G = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  localparam int unsigned NG = W / G;

  logic [W-1:0]  p;
  logic [W-2:0]  g;
  logic [NG-2:0] grp_g;
  logic [NG-2:0] grp_p;
  logic [NG-1:0] c_grp;

  assign p = x ^ y;
  assign g = x[W-2:0] & y[W-2:0];

  // Second lookahead level: carry into each group.
  assign c_grp[0] = 1'b0;
  for (genvar k = 1; k < NG; k++) begin : g_lvl2
    assign c_grp[k] = grp_g[k-1] | (grp_p[k-1] & c_grp[k-1]);
  end

  for (genvar k = 0; k < NG; k++) begin : g_grp
    logic [G-1:0] cin_v;

    if (k < NG - 1) begin : g_la
      logic gg_k;
      logic gp_k;
      always_comb begin
        gg_k = 1'b0;
        gp_k = 1'b1;
        for (int j = 0; j < G; j++) begin
          gg_k = g[k*G+j] | (p[k*G+j] & gg_k);
          gp_k = gp_k & p[k*G+j];
        end
      end
      assign grp_g[k] = gg_k;
      assign grp_p[k] = gp_k;
    end

    always_comb begin
      cin_v[0] = c_grp[k];
      for (int j = 1; j < G; j++) begin
        cin_v[j] = g[k*G+j-1] | (p[k*G+j-1] & cin_v[j-1]);
      end
    end

    assign sum[k*G +: G] = p[k*G +: G] ^ cin_v;
  end
endmodule

// File: rtl/wtree_mul.sv
module wtree_mul
  import wtm_pkg::*;
#(
  parameter int unsigned OP_W = MUL_W,
  parameter int unsigned GRP  = LA_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic              out_valid,
  output logic [2*OP_W-1:0] product
);
  localparam int unsigned PW = 2 * OP_W;

  logic [OP_W-1:0] a_q;
  logic [OP_W-1:0] b_q;
  logic            v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        a_q <= a;
        b_q <= b;
      end
    end
  end

  tree_t pp [OP_W];

  wtm_ppgen #(.OP_W(OP_W)) i_ppgen (
    .mcand (a_q),
    .mplier(b_q),
    .pp    (pp)
  );

  // Fixed reduction schedule; later stages fold earlier sums back in.
  tree_t s1, c1, s2, c2, s3, c3, s4, c4, s5, c5, s6, c6;

  wtm_csa i_csa1 (.x(pp[0]), .y(pp[1]), .z(pp[2]), .sum(s1), .carry_sh(c1));
  wtm_csa i_csa2 (.x(pp[3]), .y(pp[4]), .z(pp[5]), .sum(s2), .carry_sh(c2));
  wtm_csa i_csa3 (.x(pp[6]), .y(pp[7]), .z(s1),    .sum(s3), .carry_sh(c3));
  wtm_csa i_csa4 (.x(s2),    .y(c1),    .z(c2),    .sum(s4), .carry_sh(c4));
  wtm_csa i_csa5 (.x(s3),    .y(s4),    .z(c3),    .sum(s5), .carry_sh(c5));
  wtm_csa i_csa6 (.x(s5),    .y(c5),    .z(c4),    .sum(s6), .carry_sh(c6));

  // Named events for the checker.
  logic [PW-1:0] fin_sum;
  logic [PW-1:0] fin_car;
  logic [PW-1:0] cla_sum;

  assign fin_sum = s6;
  assign fin_car = c6;

  wtm_cla #(.W(PW), .G(GRP)) i_cla (
    .x  (fin_sum),
    .y  (fin_car),
    .sum(cla_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= v_q;
      if (v_q) begin
        product <= cla_sum;
      end
    end
  end
endmodule

// File: rtl/wtree_mul_chk.sv
module wtree_mul_chk #(
  parameter int unsigned OP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   a,
  input logic [OP_W-1:0]   b,
  input logic              out_valid,
  input logic [2*OP_W-1:0] product,
  input logic [2*OP_W-1:0] fin_sum,
  input logic [2*OP_W-1:0] fin_car,
  input logic [2*OP_W-1:0] cla_sum
);
  localparam int unsigned PW = 2 * OP_W;

  logic [PW:0] pair_total;
  assign pair_total = {1'b0, fin_sum} + {1'b0, fin_car};

  a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product == (PW'($past(a, 2)) * PW'($past(b, 2))));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(product));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pair_total[PW] == 1'b0);

  a_r8_cla_sum: assert property (@(posedge clk) disable iff (!rst_n)
    cla_sum == pair_total[PW-1:0]);
endmodule

bind wtree_mul wtree_mul_chk #(.OP_W(OP_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .a        (a),
  .b        (b),
  .out_valid(out_valid),
  .product  (product),
  .fin_sum  (fin_sum),
  .fin_car  (fin_car),
  .cla_sum  (cla_sum)
);

// File: tb/test_wtree_mul.sv
module test_wtree_mul;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W       = 8;
  localparam int PW         = 2 * OP_W;

  logic            clk      = 1'b0;
  logic            rst_n    = 1'b1;
  logic            in_valid = 1'b0;
  logic [OP_W-1:0] a        = '0;
  logic [OP_W-1:0] b        = '0;
  logic            out_valid;
  logic [PW-1:0]   product;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  wtree_mul i_wtree_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a        (a),
    .b        (b),
    .out_valid(out_valid),
    .product  (product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Present one pair, then idle; result readable two falling edges later.
  task automatic one_pair(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y);
    a = x; b = y; in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid in reset", PW'(out_valid), '0);
    chk(product === '0, "R1 product in reset", product, '0);
    rst_n = 1'b1;
    step();
    chk(out_valid === 1'b0, "R1 out_valid after reset", PW'(out_valid), '0);
  endtask

  // All pairs back to back: covers R2 R4 R7 R8.
  task automatic t_exhaustive();
    for (int n = 0; n < 65538; n++) begin
      if (n >= 2) begin
        int k;
        logic [PW-1:0] exp;
        k   = n - 2;
        exp = PW'((k >> 8) * (k & 255));
        chk(out_valid === 1'b1 && product === exp,
            "R2 R4 R7 R8 streamed product", product, exp);
      end
      if (n < 65536) begin
        a = n[15:8]; b = n[7:0]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
      step();
    end
    chk(out_valid === 1'b0, "R3 valid drops after stream", PW'(out_valid), '0);
  endtask

  task automatic t_single_bit();
    for (int i = 0; i < OP_W; i++) begin
      logic [PW-1:0] exp;
      exp = PW'(16'h00B5 << i);
      one_pair(8'hB5, 8'(1 << i));
      chk(product === exp, "R6 single multiplier bit", product, exp);
    end
    one_pair(8'hFF, 8'h00);
    chk(product === '0, "R6 zero multiplier", product, '0);
    one_pair(8'h00, 8'hFF);
    chk(product === '0, "R2 zero multiplicand", product, '0);
    one_pair(8'hFF, 8'hFF);
    chk(product === 16'hFE01, "R2 max operands", product, 16'hFE01);
  endtask

  task automatic t_idle_hold();
    a = 8'd5; b = 8'd7; in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    a = 8'hC3; b = 8'h9A;
    step();
    chk(out_valid === 1'b1, "R3 valid one cycle after capture", PW'(out_valid), 1);
    chk(product === 16'd35, "R2 idle-time product", product, 16'd35);
    a = 8'h77; b = 8'h11;
    step();
    chk(out_valid === 1'b0, "R3 no valid without capture", PW'(out_valid), '0);
    chk(product === 16'd35, "R5 product holds while idle", product, 16'd35);
    step();
    chk(product === 16'd35, "R5 idle operands ignored", product, 16'd35);
    one_pair(8'd3, 8'd4);
    chk(product === 16'd12, "R5 capture after idle", product, 16'd12);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_exhaustive();
    t_single_bit();
    t_idle_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule